// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Return Stack

This block turns a qualified interrupt request into a change of program flow for a small processor core whose instruction cycle is four clock phases long. A free-running phase counter marks the second phase of every instruction cycle. The combined request is examined only on that edge. An accepted request clears the global interrupt enable one instruction cycle later. One more instruction cycle after that, the block saves the current program counter on a hardware return stack and forces the program counter to the single fixed vector.

A return-from-interrupt strobe restores the most recent saved program counter and sets the global enable in the same step. Software can also write the global enable. If a handler enables it again, a new request is accepted and saves a further level. Only the program counter is saved, and every source shares the one vector, so there is no priority and no unmaskable input.

No data stream crosses the boundary, so there is no valid/ready handshake. Every pin is a plain control or status signal, with no back-pressure. The new program counter and its load strobe are registered outputs. The stack depth and two sticky fault flags are visible to the core.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `gie`, `pc_load`, `pc_out`, `stk_depth`, `stk_ovf` and `stk_unf` are all zero, and a held request is never accepted while `gie` is 0.
- R2: The request is examined only at the rising edge in the second phase (phase index 1, counting phases 0 to 3 from the first edge after reset). It is accepted only when `irq_req` and `gie` are both 1 on that edge.
- R3: After the accepting edge, `gie` drops 4 clocks later. 8 clocks later, `pc_out` becomes 0x0004 with a one-clock `pc_load` pulse, and `pc_in` on that edge is pushed onto the stack.
- R4: If `irq_req` rises while `gie` is 1 and the block is idle, the vector load is seen 9 to 12 clocks later, depending on the phase.
- R5: From acceptance until the vector load, further samples, `ret_strobe` and `gie_wr` are ignored.
- R6: An idle `ret_strobe` loads the top stack entry into `pc_out` with a one-clock `pc_load` pulse, removes that entry and sets `gie` on the next clock. It takes precedence over a `gie_wr` on the same clock.
- R7: An idle `gie_wr` copies `gie_wdata` into `gie` on the next clock.
- R8: A handler that sets `gie` again while a request is present is entered again. Each entry raises `stk_depth` by one, up to 8.
- R9: A push onto a full stack overwrites the oldest entry, keeps `stk_depth` at 8 and sets `stk_ovf`, which stays set until reset.
- R10: A return with an empty stack loads `pc_out` with 0, pulses `pc_load`, sets `gie`, keeps `stk_depth` at 0 and sets `stk_unf`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, four per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Combined, already masked request level |
| pc_in | input | 13 | Program counter of the interrupted flow |
| ret_strobe | input | 1 | Return-from-interrupt command, one clock |
| gie_wr | input | 1 | Software write strobe for the global enable |
| gie_wdata | input | 1 | Value written on `gie_wr` |
| pc_out | output | 13 | Program counter to load |
| pc_load | output | 1 | One-clock strobe: load `pc_out` |
| gie | output | 1 | Global interrupt enable |
| stk_depth | output | 4 | Number of saved return addresses |
| stk_ovf | output | 1 | Sticky: a push overwrote an entry |
| stk_unf | output | 1 | Sticky: a pop found the stack empty |

## Verification
The enable drop is due 4 clocks after the accepting second-phase edge, and the vector load 8 clocks after it. Returns and enable writes take effect on the clock after their strobe. The reference model in the bench counts instruction phases from reset release and counts down from acceptance. It is compared with every output on the falling edge after each rising edge, so each result is checked in the exact clock it is due. Separate checks measure the latency from the request pin to the load, which must be 9 to 12 clocks, and exercise the ignore window, nesting past the stack depth, and underflow.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_CLEAR  = 2'd1,
    SEQ_VECTOR = 2'd2
  } seq_state_t;

  localparam int unsigned PHASES_PER_CYCLE = 4;
  localparam int unsigned SAMPLE_PHASE     = 1;
endpackage

// File: rtl/irq_phase_gen.sv
module irq_phase_gen #(
  parameter int unsigned PHASES    = 4,
  parameter int unsigned SAMPLE_PH = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1;

  logic [PW-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (ph == PW'(PHASES - 1)) begin
      ph <= '0;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign tick = (ph == PW'(SAMPLE_PH));
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic irq_req,
  input  logic ret_strobe,
  input  logic gie_wr,
  input  logic gie_wdata,
  output logic gie,
  output logic busy,
  output logic gie_clr,
  output logic push,
  output logic pop
);
  seq_state_t state, state_nx;

  assign busy    = (state != SEQ_IDLE);
  assign gie_clr = tick && (state == SEQ_CLEAR);
  assign push    = tick && (state == SEQ_VECTOR);
  assign pop     = ret_strobe && !busy;

  always_comb begin
    state_nx = state;
    if (tick) begin
      unique case (state)
        SEQ_IDLE:   if (irq_req && gie) state_nx = SEQ_CLEAR;
        SEQ_CLEAR:  state_nx = SEQ_VECTOR;
        SEQ_VECTOR: state_nx = SEQ_IDLE;
        default:    state_nx = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      gie   <= 1'b0;
    end else begin
      state <= state_nx;
      if (gie_clr) begin
        gie <= 1'b0;
      end else if (pop) begin
        gie <= 1'b1;
      end else if (gie_wr && !busy) begin
        gie <= gie_wdata;
      end
    end
  end
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 push_data,
  output logic [W-1:0]                 top_data,
  output logic [$clog2(DEPTH+1)-1:0]   depth,
  output logic                         ovf,
  output logic                         unf
);
  localparam int unsigned SPW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW  = $clog2(DEPTH + 1);

  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp, sp_next, sp_prev;
  logic [CW-1:0]  cnt;

  assign sp_next  = (sp == SPW'(DEPTH - 1)) ? '0 : sp + 1'b1;
  assign sp_prev  = (sp == '0) ? SPW'(DEPTH - 1) : sp - 1'b1;
  assign top_data = (cnt == '0) ? '0 : mem[sp_prev];
  assign depth    = cnt;

  always_ff @(posedge clk) begin
    if (push) mem[sp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else if (push) begin
      sp <= sp_next;
      if (cnt == CW'(DEPTH)) ovf <= 1'b1;
      else                   cnt <= cnt + 1'b1;
    end else if (pop) begin
      if (cnt == '0) begin
        unf <= 1'b1;
      end else begin
        sp  <= sp_prev;
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned PC_W      = 13,
  parameter int unsigned DEPTH     = 8,
  parameter logic [12:0] VECTOR_PC = 13'h0004
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       irq_req,
  input  logic [PC_W-1:0]            pc_in,
  input  logic                       ret_strobe,
  input  logic                       gie_wr,
  input  logic                       gie_wdata,
  output logic [PC_W-1:0]            pc_out,
  output logic                       pc_load,
  output logic                       gie,
  output logic [$clog2(DEPTH+1)-1:0] stk_depth,
  output logic                       stk_ovf,
  output logic                       stk_unf
);
  logic           tick;
  logic           seq_busy, seq_clr, seq_push, seq_pop;
  logic [PC_W-1:0] stk_top;

  irq_phase_gen #(
    .PHASES   (PHASES_PER_CYCLE),
    .SAMPLE_PH(SAMPLE_PHASE)
  ) u_phase (
    .clk (clk),
    .rst_n(rst_n),
    .tick(tick)
  );

  irq_entry_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .irq_req   (irq_req),
    .ret_strobe(ret_strobe),
    .gie_wr    (gie_wr),
    .gie_wdata (gie_wdata),
    .gie       (gie),
    .busy      (seq_busy),
    .gie_clr   (seq_clr),
    .push      (seq_push),
    .pop       (seq_pop)
  );

  irq_ret_stack #(
    .DEPTH(DEPTH),
    .W    (PC_W)
  ) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (seq_push),
    .pop      (seq_pop),
    .push_data(pc_in),
    .top_data (stk_top),
    .depth    (stk_depth),
    .ovf      (stk_ovf),
    .unf      (stk_unf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out  <= '0;
      pc_load <= 1'b0;
    end else if (seq_push) begin
      pc_out  <= PC_W'(VECTOR_PC);
      pc_load <= 1'b1;
    end else if (seq_pop) begin
      pc_out  <= stk_top;
      pc_load <= 1'b1;
    end else begin
      pc_load <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int unsigned PC_W      = 13,
  parameter int unsigned DEPTH     = 8,
  parameter logic [12:0] VECTOR_PC = 13'h0004
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       gie,
  input logic                       busy,
  input logic                       gie_clr,
  input logic                       push,
  input logic                       pc_load,
  input logic [PC_W-1:0]            pc_out,
  input logic [$clog2(DEPTH+1)-1:0] stk_depth,
  input logic                       stk_ovf,
  input logic                       stk_unf
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!gie && !pc_load && stk_depth == '0);
    end
  end

  p_vec_follows_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> ##3 push);

  p_vector_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (pc_load && pc_out == PC_W'(VECTOR_PC)));

  p_gie_low_at_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !gie);

  p_ignore_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !gie_clr) |=> $stable(gie));

  p_depth_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= ($clog2(DEPTH+1))'(DEPTH));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf);

  p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_unf |=> stk_unf);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .PC_W     (PC_W),
  .DEPTH    (DEPTH),
  .VECTOR_PC(VECTOR_PC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gie      (gie),
  .busy     (seq_busy),
  .gie_clr  (seq_clr),
  .push     (seq_push),
  .pc_load  (pc_load),
  .pc_out   (pc_out),
  .stk_depth(stk_depth),
  .stk_ovf  (stk_ovf),
  .stk_unf  (stk_unf)
);

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic [12:0] pc_in = '0;
  logic        ret_strobe = 1'b0;
  logic        gie_wr = 1'b0;
  logic        gie_wdata = 1'b0;
  logic [12:0] pc_out;
  logic        pc_load;
  logic        gie;
  logic [3:0]  stk_depth;
  logic        stk_ovf;
  logic        stk_unf;

  always #2 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .pc_in(pc_in),
    .ret_strobe(ret_strobe), .gie_wr(gie_wr), .gie_wdata(gie_wdata),
    .pc_out(pc_out), .pc_load(pc_load), .gie(gie),
    .stk_depth(stk_depth), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cyc, m_cnt, m_pc;
  bit m_gie, m_load, m_ovf, m_unf;
  int q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0; m_cnt = 0; m_pc = 0; m_gie = 0; m_load = 0;
      m_ovf = 0; m_unf = 0; q.delete();
    end else begin
      int ph;
      bit accept;
      ph = m_cyc % 4;
      m_cyc++;
      m_load = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 4) m_gie = 0;
        if (m_cnt == 0) begin
          q.push_back(int'(pc_in));
          if (q.size() > 8) begin void'(q.pop_front()); m_ovf = 1; end
          m_pc = 4; m_load = 1;
        end
      end else begin
        accept = (ph == 1) && irq_req && m_gie;
        if (ret_strobe) begin
          if (q.size() == 0) begin m_pc = 0; m_unf = 1; end
          else m_pc = q.pop_back();
          m_load = 1; m_gie = 1;
        end else if (gie_wr) begin
          m_gie = gie_wdata;
        end
        if (accept) m_cnt = 8;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3/R6", "pc_load", pc_load, m_load);
      if (m_load) chk("R3/R6/R10", "pc_out", pc_out, m_pc);
      chk("R2/R5/R7", "gie", gie, m_gie);
      chk("R8", "stk_depth", stk_depth, q.size());
      chk("R9", "stk_ovf", stk_ovf, m_ovf);
      chk("R10", "stk_unf", stk_unf, m_unf);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 60000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_gie(input bit v);
    gie_wr = 1; gie_wdata = v;
    @(negedge clk);
    gie_wr = 0;
  endtask

  task automatic do_return();
    ret_strobe = 1;
    @(negedge clk);
    ret_strobe = 0;
  endtask

  task automatic wait_load(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!pc_load && lat < 40);
  endtask

  initial begin
    int lat;
    idle(3);
    chk("R1", "reset gie", gie, 0);
    chk("R1", "reset pc_out", pc_out, 0);
    chk("R1", "reset depth", stk_depth, 0);
    rst_n = 1;
    // R1: request held while gie is 0 is never taken
    irq_req = 1;
    lat = 0;
    for (int i = 0; i < 24; i++) begin @(negedge clk); if (pc_load) lat++; end
    chk("R1", "loads while disabled", lat, 0);
    irq_req = 0;

    // R4/R2: entry from each phase offset
    for (int k = 0; k < 4; k++) begin
      write_gie(1);
      idle(k);
      pc_in = 13'h0100 + 13'(k);
      irq_req = 1;
      wait_load(lat);
      chk("R4", "latency in range", int'(lat >= 9 && lat <= 12), 1);
      chk("R3", "vector value", pc_out, 4);
      chk("R3", "gie low in handler", gie, 0);
      irq_req = 0;
      idle(2);
      do_return();
      chk("R6", "return pc", pc_out, 32'h0100 + k);
      chk("R6", "return gie", gie, 1);
      idle(3);
    end

    // R5: strobes during the entry window are ignored
    irq_req = 1;
    pc_in = 13'h0555;
    while (gie) @(negedge clk);
    ret_strobe = 1; gie_wr = 1; gie_wdata = 1;
    idle(2);
    ret_strobe = 0; gie_wr = 0;
    wait_load(lat);
    chk("R5", "gie stays low", gie, 0);
    chk("R5", "depth one level", stk_depth, 1);
    irq_req = 0;
    do_return();
    chk("R5", "return of protected entry", pc_out, 32'h0555);

    // R6: return beats enable write on same clock
    write_gie(0);
    ret_strobe = 1; gie_wr = 1; gie_wdata = 0;
    @(negedge clk);
    ret_strobe = 0; gie_wr = 0;
    chk("R6", "return over write", gie, 1);
    // R7
    write_gie(0);
    chk("R7", "write zero", gie, 0);
    idle(5);
    while (stk_unf == 0 && 0) @(negedge clk);

    // R8/R9: nesting past the depth
    write_gie(1);
    irq_req = 1;
    for (int n = 0; n < 10; n++) begin
      pc_in = 13'h0A00 + 13'(n);
      wait_load(lat);
      chk("R8", "nested depth", stk_depth, (n + 1 > 8) ? 8 : n + 1);
      if (n < 9) write_gie(1);
    end
    chk("R9", "overflow flag", stk_ovf, 1);
    irq_req = 0;
    for (int n = 9; n >= 2; n--) begin
      do_return();
      chk("R9", "pop order after overwrite", pc_out, 32'h0A00 + n);
      write_gie(0);
    end
    chk("R9", "empty after pops", stk_depth, 0);
    // R10: underflow
    do_return();
    chk("R10", "underflow pc", pc_out, 0);
    chk("R10", "underflow flag", stk_unf, 1);
    chk("R10", "underflow gie", gie, 1);
    chk("R10", "underflow depth", stk_depth, 0);
    idle(6);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule